// File: doc/BRIEF.md
# Bitwise Lookup-Table Logic Unit

This unit evaluates any Boolean function of two or three operand words, separately at every bit position, in the way a small programmable lookup element would. The function is given as a truth table. In the three-input word mode the table is an 8-bit immediate, and the previous destination value is one of the inputs. In the two-input word mode the table is a 4-bit nibble taken from a table byte, chosen by a select bit, so the function can change at run time.

Two narrow modes work on 4-bit condition fields held in the low bits of the operands. The three-input field mode reads the table from the immediate. The two-input field mode takes its table from the low nibble of the B operand. In both field modes a 4-bit write mask decides which destination bits take the new value; the others keep their old value.

The logic is combinational. It is followed by a single output register that loads on an input strobe, so a result appears one cycle after its inputs, together with a valid strobe and a zero flag.

Top module: `bitlut_unit`

## Requirements
- R1: In mode 0 (three-input word), result bit i equals bit k of `imm`, where k = 4*dst[i] + 2*opa[i] + opb[i]. Bit 0 of `imm` is its least significant bit. If `imm` is 8'hFF, every result bit is 1.
- R2: In mode 0, `opb` is the least significant index input, `opa` the middle one and `dst` the most significant. So imm 8'hAA returns `opb`, 8'hCC returns `opa` and 8'hF0 returns `dst`.
- R3: In mode 1 (two-input word), the table is `tbl_byte[3:0]` when `nib_hi` is 0 and `tbl_byte[7:4]` when `nib_hi` is 1. The unselected nibble has no effect.
- R4: In mode 1, result bit i is table bit (2*opa[i] + opb[i]).
- R5: In mode 2 (three-input field), for i in 0..3 the unmasked value is bit (4*opb[i] + 2*opa[i] + dst[i]) of `imm`.
- R6: In mode 3 (two-input field), the table is `opb[3:0]`, and for i in 0..3 the unmasked value is table bit (2*opa[i] + dst[i]).
- R7: In modes 2 and 3, result bit i (i < 4) takes the unmasked value where `fmask[i]` is 1 and keeps `dst[i]` where it is 0. Result bits 63..4 are 0.
- R8: `zero_flag` is 1 exactly when the result is all zero in modes 0 or 1. It is always 0 for results from modes 2 and 3.
- R9: Inputs presented with `in_valid` high appear on `result` and `zero_flag` after one rising clock edge. `out_valid` is `in_valid` delayed by one cycle.
- R10: While `in_valid` is low, `result` and `zero_flag` keep their last values, whatever the other inputs do.
- R11: During reset, `out_valid`, `result` and `zero_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; loads the output register |
| mode | input | 2 | 0 word 3-in, 1 word 2-in, 2 field 3-in, 3 field 2-in |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B (holds the table in mode 3) |
| dst | input | 64 | Old destination value |
| tbl_byte | input | 8 | Table byte for mode 1 |
| imm | input | 8 | Three-input truth table |
| nib_hi | input | 1 | Selects the high nibble of `tbl_byte` |
| fmask | input | 4 | Write mask for the field modes |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Result word |
| zero_flag | output | 1 | Result-is-zero flag for the word modes |

## Verification
The only internal state is the output register. If it loads when it should not, `result` changes during an idle cycle. If it misses a load, the old value is still there one cycle after a strobe. Either fault shows at the next sampling point. A swapped index input or the wrong nibble shows up at once on the first pattern whose operands differ in that input: the three selector immediates and distinct nibbles make each role visible. A mask fault shows only on field results whose masked-out bits differ from the new value, so the patterns are chosen to make those bits differ.

// File: rtl/bitlut_pkg.sv
package bitlut_pkg;
  typedef enum logic [1:0] {
    LM_WTERN = 2'd0,
    LM_WBIN  = 2'd1,
    LM_FTERN = 2'd2,
    LM_FBIN  = 2'd3
  } lut_mode_e;

  localparam int TERN_TBL_W = 8;
  localparam int BIN_TBL_W  = 4;
endpackage

// File: rtl/bitlut_tern.sv
module bitlut_tern #(
  parameter int W = 64
) (
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_mid,
  input  logic [W-1:0] in_hi,
  input  logic [7:0]   table8,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = table8[{in_hi[i], in_mid[i], in_lo[i]}];
  end
endmodule

// File: rtl/bitlut_bin.sv
module bitlut_bin #(
  parameter int W = 64
) (
  input  logic [W-1:0] in_lo,
  input  logic [W-1:0] in_hi,
  input  logic [3:0]   table4,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = table4[{in_hi[i], in_lo[i]}];
  end
endmodule

// File: rtl/bitlut_field.sv
module bitlut_field #(
  parameter int FW      = 4,
  parameter bit TERNARY = 1'b1
) (
  input  logic [FW-1:0] fdst,
  input  logic [FW-1:0] fa,
  input  logic [FW-1:0] fb,
  input  logic [7:0]    table8,
  input  logic [FW-1:0] wmask,
  output logic [FW-1:0] y
);
  logic [FW-1:0] raw;

  if (TERNARY) begin : g_tern
    bitlut_tern #(.W(FW)) u_lut (
      .in_lo (fdst),
      .in_mid(fa),
      .in_hi (fb),
      .table8(table8),
      .y     (raw)
    );
  end else begin : g_bin
    logic [7:0] unused_tbl;
    assign unused_tbl = table8;
    bitlut_bin #(.W(FW)) u_lut (
      .in_lo (fdst),
      .in_hi (fa),
      .table4(fb[3:0]),
      .y     (raw)
    );
  end

  assign y = (raw & wmask) | (fdst & ~wmask);
endmodule

// File: rtl/bitlut_unit.sv
module bitlut_unit
  import bitlut_pkg::*;
#(
  parameter int W  = 64,
  parameter int FW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] dst,
  input  logic [7:0]   tbl_byte,
  input  logic [7:0]   imm,
  input  logic         nib_hi,
  input  logic [FW-1:0] fmask,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         zero_flag
);
  localparam int UPPER_W = W - FW;

  lut_mode_e     mode_e;
  logic [3:0]    nib_tbl;
  logic [W-1:0]  y_tern;
  logic [W-1:0]  y_bin;
  logic [FW-1:0] y_ftern;
  logic [FW-1:0] y_fbin;
  logic [W-1:0]  res_d;
  logic          zero_d;

  logic          valid_q, valid_nxt;
  logic [W-1:0]  res_q, res_nxt;
  logic          zero_q, zero_nxt;

  assign mode_e  = lut_mode_e'(mode);
  assign nib_tbl = nib_hi ? tbl_byte[7:4] : tbl_byte[3:0];

  bitlut_tern #(.W(W)) u_wtern (
    .in_lo (opb),
    .in_mid(opa),
    .in_hi (dst),
    .table8(imm),
    .y     (y_tern)
  );

  bitlut_bin #(.W(W)) u_wbin (
    .in_lo (opb),
    .in_hi (opa),
    .table4(nib_tbl),
    .y     (y_bin)
  );

  bitlut_field #(.FW(FW), .TERNARY(1'b1)) u_ftern (
    .fdst  (dst[FW-1:0]),
    .fa    (opa[FW-1:0]),
    .fb    (opb[FW-1:0]),
    .table8(imm),
    .wmask (fmask),
    .y     (y_ftern)
  );

  bitlut_field #(.FW(FW), .TERNARY(1'b0)) u_fbin (
    .fdst  (dst[FW-1:0]),
    .fa    (opa[FW-1:0]),
    .fb    (opb[FW-1:0]),
    .table8(imm),
    .wmask (fmask),
    .y     (y_fbin)
  );

  always_comb begin
    res_d  = '0;
    zero_d = 1'b0;
    unique case (mode_e)
      LM_WTERN: begin
        res_d  = y_tern;
        zero_d = (y_tern == '0);
      end
      LM_WBIN: begin
        res_d  = y_bin;
        zero_d = (y_bin == '0);
      end
      LM_FTERN: res_d = {{UPPER_W{1'b0}}, y_ftern};
      LM_FBIN:  res_d = {{UPPER_W{1'b0}}, y_fbin};
      default:  res_d = '0;
    endcase
  end

  always_comb begin
    valid_nxt = in_valid;
    res_nxt   = res_q;
    zero_nxt  = zero_q;
    if (in_valid) begin
      res_nxt  = res_d;
      zero_nxt = zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      zero_q  <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      res_q   <= res_nxt;
      zero_q  <= zero_nxt;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign zero_flag = zero_q;
endmodule

// File: rtl/bitlut_unit_chk.sv
module bitlut_unit_chk #(
  parameter int W  = 64,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic [W-1:0]  dst,
  input logic [7:0]    imm,
  input logic [FW-1:0] fmask,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          zero_flag
);
  AST_ALL_ONES_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && imm == 8'hFF) |=> (&result)); // R1

  AST_MASK_KEEPS_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> (((result[FW-1:0] ^ $past(dst[FW-1:0])) & ~$past(fmask)) == '0)); // R7

  AST_FIELD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> (result[W-1:FW] == '0)); // R7

  AST_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode[1]) |=> (zero_flag == (result == '0))); // R8

  AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode[1]) |=> !zero_flag); // R8

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(zero_flag))); // R10
endmodule

bind bitlut_unit bitlut_unit_chk #(.W(W), .FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .mode     (mode),
  .dst      (dst),
  .imm      (imm),
  .fmask    (fmask),
  .out_valid(out_valid),
  .result   (result),
  .zero_flag(zero_flag)
);

// File: tb/tb_bitlut_unit.sv
`timescale 1ns/1ps
module tb_bitlut_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  mode;
  logic [63:0] opa, opb, dst;
  logic [7:0]  tbl_byte, imm;
  logic        nib_hi;
  logic [3:0]  fmask;
  logic        out_valid;
  logic [63:0] result;
  logic        zero_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  bitlut_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .opa(opa), .opb(opb), .dst(dst), .tbl_byte(tbl_byte), .imm(imm),
    .nib_hi(nib_hi), .fmask(fmask), .out_valid(out_valid),
    .result(result), .zero_flag(zero_flag)
  );

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input logic [7:0] t,
      input logic [7:0] im, input logic nh, input logic [3:0] mk);
    logic [63:0] r;
    logic [3:0]  tb;
    r = '0;
    case (m)
      2'd0: for (int i = 0; i < 64; i++) r[i] = im[4*d[i] + 2*a[i] + b[i]];
      2'd1: begin
        tb = nh ? t[7:4] : t[3:0];
        for (int i = 0; i < 64; i++) r[i] = tb[2*a[i] + b[i]];
      end
      2'd2: for (int i = 0; i < 4; i++) r[i] = mk[i] ? im[4*b[i] + 2*a[i] + d[i]] : d[i];
      default: for (int i = 0; i < 4; i++) r[i] = mk[i] ? b[2*a[i] + d[i]] : d[i];
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] d, input logic [7:0] t, input logic [7:0] im,
      input logic nh, input logic [3:0] mk);
    @(negedge clk);
    mode = m; opa = a; opb = b; dst = d; tbl_byte = t; imm = im; nib_hi = nh; fmask = mk;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_check(input string req, input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input logic [7:0] t,
      input logic [7:0] im, input logic nh, input logic [3:0] mk);
    logic [63:0] e;
    e = model(m, a, b, d, t, im, nh, mk);
    apply(m, a, b, d, t, im, nh, mk);
    check(req, result, e);
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
  endtask

  localparam logic [63:0] PA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PB = 64'hF0F0_3C3C_AAAA_5555;
  localparam logic [63:0] PD = 64'hDEAD_BEEF_CAFE_F00D;

  task automatic test_reset();
    check("R11 result", result, 64'd0);
    check("R11 valid", {63'd0, out_valid}, 64'd0);
    check("R11 zero", {63'd0, zero_flag}, 64'd0);
  endtask

  task automatic test_tern_table();
    run_check("R1 imm96", 2'd0, PA, PB, PD, 8'h00, 8'h96, 1'b0, 4'h0);
    run_check("R1 imm1B", 2'd0, PA, PB, PD, 8'h00, 8'h1B, 1'b0, 4'h0);
    apply(2'd0, PA, PB, PD, 8'h00, 8'hFF, 1'b0, 4'h0);
    check("R1 ones", result, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic test_tern_roles();
    apply(2'd0, PA, PB, PD, 8'h00, 8'hAA, 1'b0, 4'h0);
    check("R2 opb", result, PB);
    apply(2'd0, PA, PB, PD, 8'h00, 8'hCC, 1'b0, 4'h0);
    check("R2 opa", result, PA);
    apply(2'd0, PA, PB, PD, 8'h00, 8'hF0, 1'b0, 4'h0);
    check("R2 dst", result, PD);
  endtask

  task automatic test_bin_nibble();
    apply(2'd1, PA, PB, PD, 8'h86, 8'h00, 1'b0, 4'h0);
    check("R3 low nibble", result, PA ^ PB);
    apply(2'd1, PA, PB, PD, 8'h86, 8'h00, 1'b1, 4'h0);
    check("R3 high nibble", result, PA & PB);
    apply(2'd1, PA, PB, PD, 8'hF6, 8'h00, 1'b0, 4'h0);
    check("R3 other nibble ignored", result, PA ^ PB);
  endtask

  task automatic test_bin_index();
    apply(2'd1, PA, PB, PD, 8'h0A, 8'h00, 1'b0, 4'h0);
    check("R4 picks opb", result, PB);
    apply(2'd1, PA, PB, PD, 8'h0C, 8'h00, 1'b0, 4'h0);
    check("R4 picks opa", result, PA);
    run_check("R4 table2", 2'd1, PA, PB, PD, 8'h02, 8'h00, 1'b0, 4'h0);
  endtask

  task automatic test_field_tern();
    run_check("R5 imm_E4", 2'd2, 64'h5, 64'h3, 64'h9, 8'h00, 8'hE4, 1'b0, 4'hF);
    apply(2'd2, 64'h6, 64'hC, 64'hA, 8'h00, 8'hF0, 1'b0, 4'hF);
    check("R5 selects opb field", result, 64'hC);
    apply(2'd2, 64'h6, 64'hC, 64'hA, 8'h00, 8'hAA, 1'b0, 4'hF);
    check("R5 selects dst field", result, 64'hA);
  endtask

  task automatic test_field_bin();
    apply(2'd3, 64'h3, 64'h6, 64'h5, 8'h00, 8'h00, 1'b0, 4'hF);
    check("R6 xor table", result, 64'h6);
    apply(2'd3, 64'h3, 64'hC, 64'h5, 8'h00, 8'h00, 1'b0, 4'hF);
    check("R6 opa table", result, 64'h3);
    run_check("R6 table8", 2'd3, 64'h9, 64'h8, 64'hC, 8'h00, 8'h00, 1'b0, 4'hF);
  endtask

  task automatic test_field_mask();
    apply(2'd2, 64'hFFFF_0000_0000_000F, 64'hFFFF_FFFF_0000_000F, 64'hAAAA_0000_0000_0005,
          8'h00, 8'hFF, 1'b0, 4'h6);
    check("R7 ternary mask and upper", result, 64'h7);
    apply(2'd3, 64'hF, 64'h0, 64'hFFFF_FFFF_FFFF_FFF9, 8'h00, 8'h00, 1'b0, 4'h3);
    check("R7 binary mask and upper", result, 64'h8);
    run_check("R7 mask none", 2'd2, 64'h1, 64'h2, 64'hB, 8'h00, 8'h00, 1'b0, 4'h0);
  endtask

  task automatic test_zero_flag();
    apply(2'd0, PA, PB, PD, 8'h00, 8'h00, 1'b0, 4'h0);
    check("R8 word zero", {63'd0, zero_flag}, 64'd1);
    apply(2'd1, PA, PA, PD, 8'h06, 8'h00, 1'b0, 4'h0);
    check("R8 bin zero", {63'd0, zero_flag}, 64'd1);
    apply(2'd1, PA, PB, PD, 8'h06, 8'h00, 1'b0, 4'h0);
    check("R8 bin nonzero", {63'd0, zero_flag}, 64'd0);
    apply(2'd2, 64'h0, 64'h0, 64'h0, 8'h00, 8'h00, 1'b0, 4'hF);
    check("R8 field never flags", {63'd0, zero_flag}, 64'd0);
    check("R8 field result zero", result, 64'd0);
  endtask

  task automatic test_latency();
    @(negedge clk);
    mode = 2'd0; opa = PA; opb = PB; dst = PD; imm = 8'hCC; in_valid = 1'b1;
    check("R9 before edge", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 after one edge", result, PA);
    check("R9 strobe", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R9 strobe drops", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic test_hold();
    apply(2'd0, PA, PB, PD, 8'h00, 8'hAA, 1'b0, 4'h0);
    @(negedge clk);
    mode = 2'd1; opa = '0; opb = '0; tbl_byte = 8'h00; imm = 8'h00;
    @(negedge clk);
    check("R10 held result", result, PB);
    check("R10 held zero", {63'd0, zero_flag}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 2'd0; opa = '0; opb = '0; dst = '0;
    tbl_byte = '0; imm = '0; nib_hi = 1'b0; fmask = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_tern_table();
    test_tern_roles();
    test_bin_nibble();
    test_bin_index();
    test_field_tern();
    test_field_bin();
    test_field_mask();
    test_zero_flag();
    test_latency();
    test_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule